// File: doc/BRIEF.md
# JTAG Test Access Port with I/O Reconfiguration Instruction

This block is a boundary-scan test access port controller. It runs the standard sixteen-state TAP state machine on TCK and TMS. It holds a 10-bit instruction register. Behind the instruction register sit five data registers that can be placed between TDI and TDO: a one-bit bypass stage, a 32-bit identification code, a 32-bit user code, a boundary chain of parameterised length, and an I/O-element configuration register. The boundary cells are modelled as a plain shift stage and an update latch. Each pin's output value and output enable are taken either from the core or from that latch.

A dedicated instruction reaches the I/O configuration register. It may be loaded at any time: before device configuration starts, while it runs, or after it has finished. As soon as this instruction becomes active, the active-low status output is pulled low. If a configuration is running at that moment, an abort output tells the configuration logic to stop. The status output is released only after the new configuration word has been shifted in and the TAP passes through Update-DR. A per-pin keeper flag keeps a pin from floating whenever its output enable is off. This covers the enables forced off by the high-impedance instruction and the enables that test data switches off.

Top module: `tap_ioreconf`

## Requirements
- R1: The TAP follows the sixteen-state IEEE 1149.1 transition graph on rising TCK edges. Five consecutive clocks with TMS high reach Test-Logic-Reset from any state. With USE_TRST set, trstN low forces Test-Logic-Reset asynchronously.
- R2: In Test-Logic-Reset the active instruction becomes the identification instruction (code 0x006) and nStatus is released (high). The identification value is {version[3:0], part[15:0], maker[10:0], 1'b1}; the defaults give 0x021210DD.
- R3: The instruction register is 10 bits wide and is shifted least significant bit first. Capture-IR loads 0x001, so the first two bits out are 1 then 0 and every later bit is 0.
- R4: Instruction codes: identification 0x006, user code 0x007, sample 0x005, external test 0x00F, clamp 0x00A, high-impedance 0x00B, I/O configuration 0x00D, bypass 0x3FF. Code 0x007 selects a 32-bit register that captures USERCODE_VAL.
- R5: Every code not listed in R4, together with 0x3FF, 0x00A and 0x00B, selects a one-bit bypass stage that captures 0.
- R6: TDO and its enable change only on falling TCK edges. The enable is high only while the TAP is in Shift-DR or Shift-IR.
- R7: Code 0x00D selects an IOCFG_W-bit register. Capture-DR loads the current ioCfg value into it. Update-DR copies the shifted word to ioCfg.
- R8: nStatus goes low on the Update-IR that makes 0x00D active. It returns high only on an Update-DR with 0x00D active that follows at least one Shift-DR clock since it went low.
- R9: cfgAbort is high exactly while nStatus is held low by 0x00D and cfgBusy is high.
- R10: The boundary chain has BSR_LEN = 2 x pins cells. Cell 2i carries pin i's data and cell 2i+1 carries its output enable. Capture-DR loads pinIn[i] into cell 2i and coreOe[i] into cell 2i+1. Codes 0x005 and 0x00F select the chain, and Update-DR copies it to the update latch.
- R11: Under 0x00F and 0x00A, pinOut[i] and pinOe[i] come from update-latch cells 2i and 2i+1. Under 0x00B every pinOe is 0 and pinOut follows the core. Under all other instructions, pinOut and pinOe follow coreOut and coreOe.
- R12: pinHold[i] is high whenever pinKeep[i] is high and pin i's effective output enable is off, so the keeper overrides the high-impedance state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Optional asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, updated on falling TCK |
| tdoOe | output | 1 | Output enable for tdo; tdo is high impedance when low |
| cfgBusy | input | 1 | Device configuration is in progress |
| cfgAbort | output | 1 | Request to stop the running configuration |
| nStatus | output | 1 | Active-low status, held low by the I/O configuration instruction |
| coreOut | input | BSR_LEN/2 | Functional output value per pin |
| coreOe | input | BSR_LEN/2 | Functional output enable per pin |
| pinIn | input | BSR_LEN/2 | Value observed at each pin |
| pinKeep | input | BSR_LEN/2 | Bus-hold or weak pull-up enabled per pin |
| pinOut | output | BSR_LEN/2 | Value driven toward each pin |
| pinOe | output | BSR_LEN/2 | Effective output enable per pin |
| pinHold | output | BSR_LEN/2 | Keeper active per pin |
| ioCfg | output | IOCFG_W | I/O element configuration word |

## Verification
The bench loads every one of the 1024 instruction codes. After each one it shifts a 64-bit pattern that depends on the code through the selected register. From the captured value and the offset at which the pattern reappears, it identifies both the register's length and its capture contents, so the identification code, user code, boundary chain, configuration register and bypass are each distinguished from all the others. The status sequence is tried several ways: with configuration running and with it idle, with an Update-DR that skips Shift-DR, with a full shift and update, and with an exit through Test-Logic-Reset. These show whether the release depends on a real shift and whether the abort follows cfgBusy. Pin patterns are driven through the external test, clamp, high-impedance and functional instructions with mixed keeper flags. TDO is sampled both before and after each falling edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tapState_e;

  typedef enum logic [2:0] {
    SEL_BYPASS, SEL_IDCODE, SEL_USERCODE, SEL_BOUNDARY, SEL_IOCFG
  } drSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   shift;
    logic   update;
    drSel_e sel;
    logic   drivePins;
    logic   floatPins;
  } drCtl_t;

  localparam logic [IR_W-1:0] OP_SAMPLE   = 10'h005;
  localparam logic [IR_W-1:0] OP_IDCODE   = 10'h006;
  localparam logic [IR_W-1:0] OP_USERCODE = 10'h007;
  localparam logic [IR_W-1:0] OP_CLAMP    = 10'h00A;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 10'h00B;
  localparam logic [IR_W-1:0] OP_CFGIO    = 10'h00D;
  localparam logic [IR_W-1:0] OP_EXTEST   = 10'h00F;
  localparam logic [IR_W-1:0] OP_BYPASS   = 10'h3FF;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic   tck,
  input  logic   rstN,
  input  logic   tms,
  input  logic   tdi,
  input  logic   drSo,
  input  logic   cfgBusy,
  output drCtl_t ctl,
  output logic   tdo,
  output logic   tdoOe,
  output logic   nStatus,
  output logic   cfgAbort
);

  tapState_e state, nxtState;
  logic [IR_W-1:0] irShift, irCur;
  logic holdLow, shiftSeen;
  drSel_e dSel;
  logic drive, flt;

  // TAP transition graph
  always_comb begin
    case (state)
      ST_RESET:    nxtState = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxtState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nxtState = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nxtState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nxtState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nxtState = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nxtState = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nxtState = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nxtState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nxtState = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nxtState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nxtState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nxtState = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nxtState = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nxtState = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nxtState = tms ? ST_SEL_DR   : ST_IDLE;
      default:     nxtState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nxtState;
  end

  // instruction register: shift stage and active latch
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      irShift <= '0;
      irCur   <= OP_IDCODE;
    end else begin
      if (state == ST_CAP_IR)        irShift <= IR_W'(2'b01);
      else if (state == ST_SHIFT_IR) irShift <= {tdi, irShift[IR_W-1:1]};
      if (state == ST_RESET)         irCur <= OP_IDCODE;
      else if (state == ST_UPD_IR)   irCur <= irShift;
    end
  end

  // instruction decode
  always_comb begin
    dSel  = SEL_BYPASS;
    drive = 1'b0;
    flt   = 1'b0;
    case (irCur)
      OP_IDCODE:   dSel = SEL_IDCODE;
      OP_USERCODE: dSel = SEL_USERCODE;
      OP_SAMPLE:   dSel = SEL_BOUNDARY;
      OP_EXTEST:   begin dSel = SEL_BOUNDARY; drive = 1'b1; end
      OP_CLAMP:    drive = 1'b1;
      OP_HIGHZ:    flt = 1'b1;
      OP_CFGIO:    dSel = SEL_IOCFG;
      default:     ;
    endcase
  end

  always_comb begin
    ctl.capture   = (state == ST_CAP_DR);
    ctl.shift     = (state == ST_SHIFT_DR);
    ctl.update    = (state == ST_UPD_DR);
    ctl.sel       = dSel;
    ctl.drivePins = drive;
    ctl.floatPins = flt;
  end

  // status hold: set when the reconfiguration instruction goes live,
  // cleared by an update that follows a real shift
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      holdLow   <= 1'b0;
      shiftSeen <= 1'b0;
    end else if (state == ST_RESET) begin
      holdLow   <= 1'b0;
      shiftSeen <= 1'b0;
    end else if (state == ST_UPD_IR && irShift == OP_CFGIO) begin
      holdLow   <= 1'b1;
      shiftSeen <= 1'b0;
    end else if (holdLow) begin
      if (state == ST_SHIFT_DR && irCur == OP_CFGIO) shiftSeen <= 1'b1;
      if (state == ST_UPD_DR && irCur == OP_CFGIO && shiftSeen) holdLow <= 1'b0;
    end
  end

  assign nStatus  = ~holdLow;
  assign cfgAbort = holdLow & cfgBusy;

  // output stage on the falling edge
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdoOe <= (state == ST_SHIFT_DR) || (state == ST_SHIFT_IR);
      tdo   <= (state == ST_SHIFT_IR) ? irShift[0] : drSo;
    end
  end

  assert_five_tms_R1: assert property (@(posedge tck) disable iff (!rstN)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == ST_RESET);

  assert_reset_selects_id_R2: assert property (@(posedge tck) disable iff (!rstN)
    ($past(state) == ST_RESET) |-> ctl.sel == SEL_IDCODE);

  assert_tdo_enable_R6: assert property (@(posedge tck) disable iff (!rstN)
    tdoOe |-> (state == ST_SHIFT_DR || state == ST_SHIFT_IR));

  assert_hold_set_R8: assert property (@(posedge tck) disable iff (!rstN)
    $rose(holdLow) |-> $past(state) == ST_UPD_IR);

  assert_hold_clear_R8: assert property (@(posedge tck) disable iff (!rstN)
    $fell(holdLow) |-> ($past(state) == ST_UPD_DR || $past(state) == ST_RESET));

endmodule

// File: rtl/tap_dpath.sv
module tap_dpath
  import tap_pkg::*;
#(
  parameter int          BSR_LEN      = 16,
  parameter int          IOCFG_W      = 16,
  parameter logic [31:0] IDCODE_VAL   = 32'h0000_0001,
  parameter logic [31:0] USERCODE_VAL = 32'h0000_0000
) (
  input  logic                 tck,
  input  logic                 rstN,
  input  logic                 tdi,
  input  drCtl_t               ctl,
  input  logic [BSR_LEN/2-1:0] coreOut,
  input  logic [BSR_LEN/2-1:0] coreOe,
  input  logic [BSR_LEN/2-1:0] pinIn,
  input  logic [BSR_LEN/2-1:0] pinKeep,
  output logic                 drSo,
  output logic [BSR_LEN/2-1:0] pinOut,
  output logic [BSR_LEN/2-1:0] pinOe,
  output logic [BSR_LEN/2-1:0] pinHold,
  output logic [IOCFG_W-1:0]   ioCfg
);

  localparam int NUM_PINS = BSR_LEN / 2;
  localparam int ID_W     = 32;

  logic                bypassBit;
  logic [ID_W-1:0]     idShift;
  logic [BSR_LEN-1:0]  bsrShift, bsrUpd, bsrCap;
  logic [IOCFG_W-1:0]  cfgShift;

  // per-pin boundary cells and pin muxing
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic oeEff;
    assign bsrCap[2*p]   = pinIn[p];
    assign bsrCap[2*p+1] = coreOe[p];
    assign oeEff      = ctl.floatPins ? 1'b0 :
                        (ctl.drivePins ? bsrUpd[2*p+1] : coreOe[p]);
    assign pinOut[p]  = ctl.drivePins ? bsrUpd[2*p] : coreOut[p];
    assign pinOe[p]   = oeEff;
    assign pinHold[p] = pinKeep[p] & ~oeEff;
  end

  // capture / shift stages
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bypassBit <= 1'b0;
      idShift   <= '0;
      bsrShift  <= '0;
      cfgShift  <= '0;
    end else if (ctl.capture) begin
      bypassBit <= 1'b0;
      idShift   <= (ctl.sel == SEL_USERCODE) ? USERCODE_VAL : IDCODE_VAL;
      bsrShift  <= bsrCap;
      cfgShift  <= ioCfg;
    end else if (ctl.shift) begin
      case (ctl.sel)
        SEL_BYPASS:               bypassBit <= tdi;
        SEL_IDCODE, SEL_USERCODE: idShift   <= {tdi, idShift[ID_W-1:1]};
        SEL_BOUNDARY:             bsrShift  <= {tdi, bsrShift[BSR_LEN-1:1]};
        SEL_IOCFG:                cfgShift  <= {tdi, cfgShift[IOCFG_W-1:1]};
        default:                  ;
      endcase
    end
  end

  // update latches
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bsrUpd <= '0;
      ioCfg  <= '0;
    end else if (ctl.update) begin
      if (ctl.sel == SEL_BOUNDARY) bsrUpd <= bsrShift;
      if (ctl.sel == SEL_IOCFG)    ioCfg  <= cfgShift;
    end
  end

  always_comb begin
    case (ctl.sel)
      SEL_IDCODE, SEL_USERCODE: drSo = idShift[0];
      SEL_BOUNDARY:             drSo = bsrShift[0];
      SEL_IOCFG:                drSo = cfgShift[0];
      default:                  drSo = bypassBit;
    endcase
  end

  assert_bypass_capture_R5: assert property (@(posedge tck) disable iff (!rstN)
    (ctl.capture && ctl.sel == SEL_BYPASS) |=> drSo == 1'b0);

  assert_cfg_update_R7: assert property (@(posedge tck) disable iff (!rstN)
    (ctl.update && ctl.sel == SEL_IOCFG) |=> ioCfg == $past(cfgShift));

  assert_bsr_update_R10: assert property (@(posedge tck) disable iff (!rstN)
    (ctl.update && ctl.sel == SEL_BOUNDARY) |=> bsrUpd == $past(bsrShift));

endmodule

// File: rtl/tap_ioreconf.sv
module tap_ioreconf #(
  parameter bit          USE_TRST     = 1'b1,
  parameter int          BSR_LEN      = 16,
  parameter int          IOCFG_W      = 16,
  parameter logic [3:0]  ID_VERSION   = 4'h0,
  parameter logic [15:0] ID_PART      = 16'h2121,
  parameter logic [10:0] ID_MAKER     = 11'h06E,
  parameter logic [31:0] USERCODE_VAL = 32'hA5C3_0F1E
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic                 tms,
  input  logic                 tdi,
  output logic                 tdo,
  output logic                 tdoOe,
  input  logic                 cfgBusy,
  output logic                 cfgAbort,
  output logic                 nStatus,
  input  logic [BSR_LEN/2-1:0] coreOut,
  input  logic [BSR_LEN/2-1:0] coreOe,
  input  logic [BSR_LEN/2-1:0] pinIn,
  input  logic [BSR_LEN/2-1:0] pinKeep,
  output logic [BSR_LEN/2-1:0] pinOut,
  output logic [BSR_LEN/2-1:0] pinOe,
  output logic [BSR_LEN/2-1:0] pinHold,
  output logic [IOCFG_W-1:0]   ioCfg
);

  localparam logic [31:0] IDCODE_VAL = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  tap_pkg::drCtl_t ctl;
  logic drSo;
  logic rstN;

  assign rstN = USE_TRST ? trstN : 1'b1;

  tap_ctrl i_ctrl (
    .tck(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .drSo(drSo),
    .cfgBusy(cfgBusy), .ctl(ctl), .tdo(tdo), .tdoOe(tdoOe),
    .nStatus(nStatus), .cfgAbort(cfgAbort)
  );

  tap_dpath #(
    .BSR_LEN(BSR_LEN), .IOCFG_W(IOCFG_W),
    .IDCODE_VAL(IDCODE_VAL), .USERCODE_VAL(USERCODE_VAL)
  ) i_dpath (
    .tck(tck), .rstN(rstN), .tdi(tdi), .ctl(ctl),
    .coreOut(coreOut), .coreOe(coreOe), .pinIn(pinIn), .pinKeep(pinKeep),
    .drSo(drSo), .pinOut(pinOut), .pinOe(pinOe), .pinHold(pinHold), .ioCfg(ioCfg)
  );

endmodule

// File: tb/test_tap_ioreconf.sv
module test_tap_ioreconf;

  localparam int NP = 8;
  localparam int BL = 16;
  localparam int CW = 16;
  localparam logic [31:0] ID_EXP = {4'h0, 16'h2121, 11'h06E, 1'b1};
  localparam logic [31:0] UC_EXP = 32'hA5C3_0F1E;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0, cfgBusy = 1'b0;
  logic [NP-1:0] coreOut = '0, coreOe = '0, pinIn = '0, pinKeep = '0;
  logic tdo, tdoOe, cfgAbort, nStatus;
  logic [NP-1:0] pinOut, pinOe, pinHold;
  logic [CW-1:0] ioCfg;

  tap_ioreconf i_tap_ioreconf (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoOe(tdoOe),
    .cfgBusy(cfgBusy), .cfgAbort(cfgAbort), .nStatus(nStatus),
    .coreOut(coreOut), .coreOe(coreOe), .pinIn(pinIn), .pinKeep(pinKeep),
    .pinOut(pinOut), .pinOe(pinOe), .pinHold(pinHold), .ioCfg(ioCfg)
  );

  always #10 tck = ~tck;

  int nCmp = 0, nBad = 0;
  bit done = 0;
  logic sTdo, sOe, hiTdo, nsAtExit, oeBad = 1'b0;
  logic [CW-1:0] modelCfg = '0;

  task automatic chk(input string msg, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  // one TCK cycle: drive while low, sample before and after the falling edge
  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); #2 hiTdo = tdo;
    @(negedge tck); #2 sTdo = tdo; sOe = tdoOe;
  endtask

  task automatic scanIr(input logic [9:0] code, output logic [9:0] cap);
    cap = '0;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = sTdo; if (!sOe) oeBad = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step(i == 9, code[i]);
      if (i < 9) begin cap[i+1] = sTdo; if (!sOe) oeBad = 1'b1; end
      else if (sOe) oeBad = 1'b1;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scanDr(input logic [63:0] din, input int n, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = sTdo; if (!sOe) oeBad = 1'b1;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      if (i < n - 1) begin dout[i+1] = sTdo; if (!sOe) oeBad = 1'b1; end
      else begin nsAtExit = nStatus; if (sOe) oeBad = 1'b1; end
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [NP-1:0] evenBits(input logic [BL-1:0] v);
    for (int i = 0; i < NP; i++) evenBits[i] = v[2*i];
  endfunction
  function automatic logic [NP-1:0] oddBits(input logic [BL-1:0] v);
    for (int i = 0; i < NP; i++) oddBits[i] = v[2*i+1];
  endfunction

  initial begin
    repeat (190000) @(posedge tck);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [9:0]  cap;
    logic [63:0] dout, din, expOut, capV;
    logic [BL-1:0] bsrCapV, pat;
    int len;
    string tag;

    // reset state
    repeat (3) @(negedge tck);
    #2;
    chk("R1 reset nStatus", nStatus, 1);
    chk("R9 reset cfgAbort", cfgAbort, 0);
    chk("R6 reset tdoOe", tdoOe, 0);
    trstN = 1'b1;
    step(1, 0); step(0, 0);

    // R2: identification selected straight after reset
    scanDr(64'h0, 32, dout);
    chk("R2 id after reset", dout[31:0], ID_EXP);

    // sweep all instruction codes
    pinIn = 8'hC5; coreOe = 8'h3A; coreOut = 8'h96; pinKeep = 8'h0F;
    for (int k = 0; k < NP; k++) begin
      bsrCapV[2*k] = pinIn[k]; bsrCapV[2*k+1] = coreOe[k];
    end
    for (int c = 0; c < 1024; c++) begin
      scanIr(10'(c), cap);
      chk($sformatf("R3 ir capture code %h", c), 64'(cap), 64'h001);
      din = {32'(c) * 32'h9E37_79B1, 32'hC3A5_0000 ^ 32'(c)};
      case (10'(c))
        10'h006: begin len = 32; capV = 64'(ID_EXP); tag = "R2"; end
        10'h007: begin len = 32; capV = 64'(UC_EXP); tag = "R4"; end
        10'h005, 10'h00F: begin len = BL; capV = 64'(bsrCapV); tag = "R10"; end
        10'h00D: begin len = CW; capV = 64'(modelCfg); tag = "R7"; end
        default: begin len = 1; capV = 64'h0; tag = "R5"; end
      endcase
      for (int b = 0; b < 64; b++) expOut[b] = (b < len) ? capV[b] : din[b - len];
      scanDr(din, 64, dout);
      chk($sformatf("%s dr scan code %h", tag, c), dout, expOut);
      if (c == 10'h00D) modelCfg = din[63 -: CW];
    end
    chk("R7 ioCfg after sweep", 64'(ioCfg), 64'(modelCfg));
    chk("R6 tdo enable in sweep", 64'(oeBad), 0);

    // R8/R9: reconfiguration during configuration
    cfgBusy = 1'b1;
    scanIr(10'h00D, cap);
    chk("R8 nStatus low after IR update", nStatus, 0);
    chk("R9 abort while busy", cfgAbort, 1);
    step(1, 0); step(0, 0); step(1, 0); step(1, 0); step(0, 0);
    chk("R8 update without shift keeps low", nStatus, 0);
    cfgBusy = 1'b0; #1;
    chk("R9 abort follows busy", cfgAbort, 0);
    cfgBusy = 1'b1; #1;
    scanDr(64'h5A3C, CW, dout);
    chk("R7 capture old cfg", dout[CW-1:0], modelCfg);
    chk("R8 still low before update", nsAtExit, 0);
    chk("R8 released after update", nStatus, 1);
    chk("R9 abort gone after release", cfgAbort, 0);
    chk("R7 cfg written", ioCfg, 16'h5A3C);
    modelCfg = 16'h5A3C;

    // R9: issued while idle
    cfgBusy = 1'b0;
    scanIr(10'h00D, cap);
    chk("R8 low when idle", nStatus, 0);
    chk("R9 no abort when idle", cfgAbort, 0);

    // R1/R2: five TMS-high clocks release status and restore identification
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R2 nStatus released by reset state", nStatus, 1);
    step(0, 0);
    scanDr(64'h0, 32, dout);
    chk("R1 five tms to reset then id", dout[31:0], ID_EXP);
    chk("R7 cfg kept over reset state", ioCfg, modelCfg);

    // R1: asynchronous TRST
    scanIr(10'h007, cap);
    scanDr(64'h0, 32, dout);
    chk("R4 usercode", dout[31:0], UC_EXP);
    trstN = 1'b0; #3; trstN = 1'b1;
    step(0, 0);
    scanDr(64'h0, 32, dout);
    chk("R1 trst then id", dout[31:0], ID_EXP);

    // R10..R12: pin control
    for (int t = 0; t < 6; t++) begin
      pat = 16'(t * 16'h3B1D + 16'h1234);
      pinKeep = 8'(t * 8'h2D + 8'h55);
      coreOut = 8'(t * 8'h13 + 8'h0F);
      coreOe  = 8'(t * 8'h71 + 8'hA0);
      scanIr(10'h00F, cap);
      scanDr(64'(pat), BL, dout);
      chk($sformatf("R11 extest out %0d", t), pinOut, evenBits(pat));
      chk($sformatf("R11 extest oe %0d", t), pinOe, oddBits(pat));
      chk($sformatf("R12 extest hold %0d", t), pinHold, pinKeep & ~oddBits(pat));
      scanIr(10'h00B, cap);
      chk($sformatf("R11 highz oe %0d", t), pinOe, 0);
      chk($sformatf("R11 highz out %0d", t), pinOut, coreOut);
      chk($sformatf("R12 highz hold %0d", t), pinHold, pinKeep);
      scanIr(10'h00A, cap);
      chk($sformatf("R11 clamp out %0d", t), pinOut, evenBits(pat));
      chk($sformatf("R11 clamp oe %0d", t), pinOe, oddBits(pat));
      scanIr(10'h006, cap);
      chk($sformatf("R11 functional out %0d", t), pinOut, coreOut);
      chk($sformatf("R11 functional oe %0d", t), pinOe, coreOe);
      chk($sformatf("R12 functional hold %0d", t), pinHold, pinKeep & ~coreOe);
    end

    // R5/R6: bypass stream and falling-edge output timing
    begin
      logic prev;
      logic [7:0] bp;
      bp = 8'b1011_0010;
      scanIr(10'h3FF, cap);
      step(1, 0); step(0, 0); step(0, 0);
      chk("R5 bypass captures 0", sTdo, 0);
      prev = sTdo;
      for (int i = 0; i < 8; i++) begin
        step(0, bp[i]);
        chk("R6 tdo stable until falling edge", hiTdo, prev);
        chk("R5 bypass one-bit delay", sTdo, bp[i]);
        prev = sTdo;
      end
      step(1, 0);
      chk("R6 enable off after shift", sOe, 0);
      step(1, 0); step(0, 0);
      chk("R6 enable off in idle", tdoOe, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule